// File: doc/BRIEF.md
# Infrared Transceiver Mode Decoder with Stuck-Emitter Guard

This block is the control logic inside an infrared transceiver that can send both serial infrared data and remote-control codes. It watches three host-driven inputs: a shutdown/programming strobe, a data-transmit line and a remote-control transmit line. From them it decodes mode-programming pulses, tracks full shutdown, and drives the enables for the data emitter, the remote-control emitter and the receiver.

The length of a strobe pulse sets its meaning. A short pulse programs the block: the level of the data-transmit line at the strobe's falling edge picks the receive bandwidth, and a long enough data-transmit pulse inside the strobe instead selects remote-control steering. A long pulse shuts the block down and restores the default mode. A pulse whose length falls between the two limits is ignored. A guard timer on each transmit input turns its emitter off when the input is held high too long. All time limits are parameters counted in clock cycles, and all inputs pass through two-stage synchronizers first.

Top module: `irx_mode_ctrl`

## Requirements
- R1: After reset both emitter enables are 0, `bwHigh` is 0 (low bandwidth), and `rxEn` and `rxOutEn` are 1.
- R2: A `sdIn` pulse of at most PROG_MAX_CYC cycles is a programming pulse. On its falling edge, `txIrIn`=1 sets `bwHigh` to 1 and leaves remote-control steering off. `txIrIn`=0 with no qualifying inner pulse sets `bwHigh` to 0 and leaves steering off.
- R3: When `sdIn` stays high for SHUT_MIN_CYC cycles, the block enters shutdown. Both emitter enables go to 0, `rxEn` and `rxOutEn` go to 0, `bwHigh` returns to 0 and remote-control steering is cleared. Shutdown ends when `sdIn` falls, and that falling edge programs nothing.
- R4: With `sdIn` low and steering off, `txIrIn` alone drives `irLedEn` and `txRcIn` alone drives `rcLedEn`. With both inputs low, both enables are 0 and the receiver stays enabled.
- R5: When `txIrIn` and `txRcIn` are both high, both emitter enables are 0.
- R6: An emitter enable stays on for at most STUCK_MAX_CYC cycles of continuous high on its input, then stays off until that input goes low. The next high on that input drives the emitter again.
- R7: During a programming pulse, a `txIrIn` high of at least RC_MIN_CYC cycles that ends before the falling edge enables steering. While steering is on, `txIrIn` drives `rcLedEn` and never `irLedEn`. Steering stays on until the next programming pulse or shutdown.
- R8: A `sdIn` pulse longer than PROG_MAX_CYC but shorter than SHUT_MIN_CYC leaves `bwHigh` and steering unchanged.
- R9: While `sdIn` is high, both emitter enables are 0, whatever the transmit inputs do.
- R10: An emitter enable follows a transmit-input change on the third rising clock edge: two synchronizer stages, then the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sdIn | input | 1 | Shutdown / programming strobe, active high |
| txIrIn | input | 1 | Data transmit input, active high |
| txRcIn | input | 1 | Remote-control transmit input, active high |
| irLedEn | output | 1 | Data emitter enable |
| rcLedEn | output | 1 | Remote-control emitter enable |
| bwHigh | output | 1 | 1 selects high receive bandwidth, 0 selects low |
| rxEn | output | 1 | Receiver enable |
| rxOutEn | output | 1 | Receive-output driver enable (0 means high impedance) |

## Verification
Some properties are checked on every cycle:
- The two emitter enables are never on together.
- Shutdown keeps both emitters dark and resets the bandwidth bit.
- A saturated guard timer with its input still high turns the emitters off in the next cycle.
- At most one programming or shutdown strobe is active in any cycle.

Other behaviour needs whole pulse sequences, so only the bench scenarios show it. This covers the pulse-length classes (programming, ignored, shutdown), the choice between bandwidth and steering at the strobe's falling edge, re-arming of the guard timer, and the exact three-edge latency. Mixed random drive of the transmit inputs in each programmed mode covers the decode table.

// File: rtl/irx_pkg.sv
package irx_pkg;

  // Synchronized levels and one-cycle strobes from control to datapath
  typedef struct packed {
    logic sdLvl;
    logic irLvl;
    logic rcLvl;
    logic selHigh;
    logic selLow;
    logic selRc;
    logic shutSet;
    logic shutClr;
  } irxStrobe_t;

endpackage

// File: rtl/irx_ctrl.sv
module irx_ctrl
  import irx_pkg::*;
#(
  parameter int PROG_MAX_CYC = 500,
  parameter int SHUT_MIN_CYC = 3000,
  parameter int RC_MIN_CYC   = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sdIn,
  input  logic       txIrIn,
  input  logic       txRcIn,
  output irxStrobe_t strb
);

  localparam int SD_W = $clog2(SHUT_MIN_CYC + 1);
  localparam int RC_W = $clog2(RC_MIN_CYC + 1);
  localparam logic [SD_W-1:0] SD_SAT    = SD_W'(SHUT_MIN_CYC);
  localparam logic [SD_W-1:0] SD_LAST   = SD_W'(SHUT_MIN_CYC - 1);
  localparam logic [SD_W-1:0] PROG_LIM  = SD_W'(PROG_MAX_CYC);
  localparam logic [RC_W-1:0] RC_SAT    = RC_W'(RC_MIN_CYC);
  localparam logic [RC_W-1:0] RC_LAST   = RC_W'(RC_MIN_CYC - 1);
  localparam int NUM_IN = 3;

  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] syncA;
  logic [NUM_IN-1:0] syncB;

  assign rawIn = {txRcIn, txIrIn, sdIn};

  // Two-stage synchronizer on every input
  for (genvar i = 0; i < NUM_IN; i++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA[i] <= 1'b0;
        syncB[i] <= 1'b0;
      end else begin
        syncA[i] <= rawIn[i];
        syncB[i] <= syncA[i];
      end
    end
  end

  logic sdS, irS, rcS;
  assign sdS = syncB[0];
  assign irS = syncB[1];
  assign rcS = syncB[2];

  logic            sdPrev;
  logic [SD_W-1:0] sdCnt;
  logic [RC_W-1:0] irCnt;
  logic            rcSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdPrev <= 1'b0;
      sdCnt  <= '0;
      irCnt  <= '0;
      rcSeen <= 1'b0;
    end else begin
      sdPrev <= sdS;
      if (!sdS)                sdCnt <= '0;
      else if (sdCnt != SD_SAT) sdCnt <= sdCnt + 1'b1;
      if (sdS && irS) begin
        if (irCnt != RC_SAT) irCnt <= irCnt + 1'b1;
      end else begin
        irCnt <= '0;
      end
      if (!sdS)                         rcSeen <= 1'b0;
      else if (irS && irCnt == RC_LAST) rcSeen <= 1'b1;
    end
  end

  logic sdFall, progOk;
  assign sdFall = sdPrev & ~sdS;
  assign progOk = sdFall && (sdCnt <= PROG_LIM);

  always_comb begin
    strb.sdLvl   = sdS;
    strb.irLvl   = irS;
    strb.rcLvl   = rcS;
    strb.selHigh = progOk & irS;
    strb.selRc   = progOk & ~irS & rcSeen;
    strb.selLow  = progOk & ~irS & ~rcSeen;
    strb.shutSet = sdS && (sdCnt == SD_LAST);
    strb.shutClr = ~sdS;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.selHigh, strb.selLow, strb.selRc, strb.shutSet})); // R2
  AST_FALL_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (strb.selHigh || strb.selLow || strb.selRc) |-> $past(sdS)); // R8

endmodule

// File: rtl/irx_dp.sv
module irx_dp
  import irx_pkg::*;
#(
  parameter int STUCK_MAX_CYC = 5000
) (
  input  logic       clk,
  input  logic       rstN,
  input  irxStrobe_t strb,
  output logic       irLedEn,
  output logic       rcLedEn,
  output logic       bwHigh,
  output logic       rxEn,
  output logic       rxOutEn
);

  localparam int ST_W = $clog2(STUCK_MAX_CYC + 1);
  localparam logic [ST_W-1:0] ST_SAT = ST_W'(STUCK_MAX_CYC);
  localparam int NUM_TX = 2;

  logic [NUM_TX-1:0] txLvl;
  logic [NUM_TX-1:0] txOk;
  logic [ST_W-1:0]   stuckCnt [NUM_TX];

  assign txLvl = {strb.rcLvl, strb.irLvl};

  // Guard timer per transmit input
  for (genvar i = 0; i < NUM_TX; i++) begin : g_guard
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                     stuckCnt[i] <= '0;
      else if (!txLvl[i])            stuckCnt[i] <= '0;
      else if (stuckCnt[i] != ST_SAT) stuckCnt[i] <= stuckCnt[i] + 1'b1;
    end
    assign txOk[i] = txLvl[i] && (stuckCnt[i] != ST_SAT);

    AST_GUARD_CUTS: assert property (@(posedge clk) disable iff (!rstN)
      (stuckCnt[i] == ST_SAT && txLvl[i]) |=> (!irLedEn && !rcLedEn)); // R6
  end

  logic shutState, rcMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shutState <= 1'b0;
      bwHigh    <= 1'b0;
      rcMode    <= 1'b0;
    end else if (strb.shutSet) begin
      shutState <= 1'b1;
      bwHigh    <= 1'b0;
      rcMode    <= 1'b0;
    end else begin
      if (strb.shutClr) shutState <= 1'b0;
      if (strb.selHigh) begin
        bwHigh <= 1'b1;
        rcMode <= 1'b0;
      end else if (strb.selLow) begin
        bwHigh <= 1'b0;
        rcMode <= 1'b0;
      end else if (strb.selRc) begin
        rcMode <= 1'b1;
      end
    end
  end

  logic soloIr, soloRc, drvGate, irNext, rcNext;
  assign soloIr  = txOk[0] & ~strb.rcLvl;
  assign soloRc  = txOk[1] & ~strb.irLvl;
  assign drvGate = ~strb.sdLvl & ~shutState;
  assign irNext  = drvGate & soloIr & ~rcMode;
  assign rcNext  = drvGate & (soloRc | (soloIr & rcMode));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irLedEn <= 1'b0;
      rcLedEn <= 1'b0;
    end else begin
      irLedEn <= irNext;
      rcLedEn <= rcNext;
    end
  end

  assign rxEn    = ~shutState;
  assign rxOutEn = ~shutState;

  AST_NO_DUAL_LED: assert property (@(posedge clk) disable iff (!rstN)
    !(irLedEn && rcLedEn)); // R5
  AST_SHUT_DARK: assert property (@(posedge clk) disable iff (!rstN)
    shutState |-> (!irLedEn && !rcLedEn)); // R3
  AST_SHUT_LOWBW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shutState) |-> !bwHigh); // R3
  AST_STROBE_DARK: assert property (@(posedge clk) disable iff (!rstN)
    strb.sdLvl |=> (!irLedEn && !rcLedEn)); // R9

endmodule

// File: rtl/irx_mode_ctrl.sv
module irx_mode_ctrl
  import irx_pkg::*;
#(
  parameter int PROG_MAX_CYC  = 500,
  parameter int SHUT_MIN_CYC  = 3000,
  parameter int RC_MIN_CYC    = 20,
  parameter int STUCK_MAX_CYC = 5000
) (
  input  logic clk,
  input  logic rstN,
  input  logic sdIn,
  input  logic txIrIn,
  input  logic txRcIn,
  output logic irLedEn,
  output logic rcLedEn,
  output logic bwHigh,
  output logic rxEn,
  output logic rxOutEn
);

  irxStrobe_t strb;

  irx_ctrl #(
    .PROG_MAX_CYC(PROG_MAX_CYC),
    .SHUT_MIN_CYC(SHUT_MIN_CYC),
    .RC_MIN_CYC  (RC_MIN_CYC)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .sdIn  (sdIn),
    .txIrIn(txIrIn),
    .txRcIn(txRcIn),
    .strb  (strb)
  );

  irx_dp #(
    .STUCK_MAX_CYC(STUCK_MAX_CYC)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .irLedEn(irLedEn),
    .rcLedEn(rcLedEn),
    .bwHigh (bwHigh),
    .rxEn   (rxEn),
    .rxOutEn(rxOutEn)
  );

endmodule

// File: tb/irx_mode_ctrl_bench.sv
module irx_mode_ctrl_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sdIn = 1'b0;
  logic txIrIn = 1'b0;
  logic txRcIn = 1'b0;
  logic irLedEn, rcLedEn, bwHigh, rxEn, rxOutEn;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit mBw = 0;
  bit mRc = 0;

  always #5 clk = ~clk;

  irx_mode_ctrl u_irx_mode_ctrl (
    .clk(clk), .rstN(rstN), .sdIn(sdIn), .txIrIn(txIrIn), .txRcIn(txRcIn),
    .irLedEn(irLedEn), .rcLedEn(rcLedEn), .bwHigh(bwHigh),
    .rxEn(rxEn), .rxOutEn(rxOutEn)
  );

  function automatic bit expIr(bit ir, bit rc, bit rcm);
    return ir & ~rc & ~rcm;
  endfunction

  function automatic bit expRc(bit ir, bit rc, bit rcm);
    return (rc & ~ir) | (ir & ~rc & rcm);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // mode: 0 low bandwidth, 1 high bandwidth, 2 remote-control steering
  task automatic doProg(input int mode);
    @(negedge clk);
    sdIn = 1'b1;
    if (mode == 1) begin
      idle(95); txIrIn = 1'b1; idle(5);
      sdIn = 1'b0; idle(3); txIrIn = 1'b0;
      mBw = 1; mRc = 0;
    end else if (mode == 2) begin
      idle(3); txIrIn = 1'b1; idle(25); txIrIn = 1'b0; idle(72);
      sdIn = 1'b0;
      mRc = 1;
    end else begin
      idle(100); sdIn = 1'b0;
      mBw = 0; mRc = 0;
    end
    idle(8);
  endtask

  task automatic drive(input bit ir, input bit rc, input string req);
    txIrIn = ir; txRcIn = rc;
    idle(5);
    chk(req, irLedEn, expIr(ir, rc, mRc));
    chk(req, rcLedEn, expRc(ir, rc, mRc));
    txIrIn = 1'b0; txRcIn = 1'b0;
    idle(5);
  endtask

  initial begin
    #(190000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd4242);
    idle(3);
    // R1 reset state
    chk("R1 irLedEn", irLedEn, 1'b0);
    chk("R1 rcLedEn", rcLedEn, 1'b0);
    chk("R1 bwHigh", bwHigh, 1'b0);
    chk("R1 rxEn", rxEn, 1'b1);
    chk("R1 rxOutEn", rxOutEn, 1'b1);
    rstN = 1'b1;
    idle(3);

    // R10 latency: two synchronizer edges then output edge
    txIrIn = 1'b1;
    idle(2);
    chk("R10 before third edge", irLedEn, 1'b0);
    idle(1);
    chk("R10 at third edge", irLedEn, 1'b1);
    txIrIn = 1'b0; idle(5);

    // R4 direct drive and idle
    drive(1, 0, "R4 ir alone");
    drive(0, 1, "R4 rc alone");
    drive(0, 0, "R4 idle");
    chk("R4 idle rxEn", rxEn, 1'b1);
    // R5 both high
    drive(1, 1, "R5 both high");

    // R2 bandwidth programming
    doProg(1);
    chk("R2 high select", bwHigh, 1'b1);
    drive(1, 0, "R2 ir after high");
    doProg(0);
    chk("R2 low select", bwHigh, 1'b0);
    doProg(1);

    // R8 mid-length pulse ignored
    sdIn = 1'b1; idle(1000); sdIn = 1'b0; idle(8);
    chk("R8 mid pulse keeps bw", bwHigh, 1'b1);
    chk("R8 mid pulse keeps rx", rxEn, 1'b1);

    // R9 emitters dark while strobe high (short pulse, ends as low select)
    sdIn = 1'b1; idle(2); txIrIn = 1'b1; idle(5);
    chk("R9 ir dark in strobe", irLedEn, 1'b0);
    chk("R9 rc dark in strobe", rcLedEn, 1'b0);
    txIrIn = 1'b0; idle(2); sdIn = 1'b0; idle(8);
    mBw = 0; mRc = 0;
    chk("R9 short pulse low select", bwHigh, 1'b0);

    // R7 steering
    doProg(2);
    drive(1, 0, "R7 ir steers rc");
    drive(0, 1, "R7 rc input in steering");
    drive(1, 1, "R7 both high in steering");
    doProg(0);
    drive(1, 0, "R7 steering cleared");

    // R3 shutdown from high bandwidth with steering
    doProg(1);
    doProg(2);
    sdIn = 1'b1; txIrIn = 1'b1; idle(3100);
    chk("R3 shut rxEn", rxEn, 1'b0);
    chk("R3 shut rxOutEn", rxOutEn, 1'b0);
    chk("R3 shut bw", bwHigh, 1'b0);
    chk("R3 shut ir", irLedEn, 1'b0);
    chk("R3 shut rc", rcLedEn, 1'b0);
    txIrIn = 1'b0; sdIn = 1'b0; idle(8);
    mBw = 0; mRc = 0;
    chk("R3 exit rxEn", rxEn, 1'b1);
    chk("R3 exit bw", bwHigh, 1'b0);
    drive(1, 0, "R3 steering cleared by shutdown");

    // R6 guard timer on data input
    txIrIn = 1'b1; idle(4990);
    chk("R6 ir still on", irLedEn, 1'b1);
    idle(20);
    chk("R6 ir cut", irLedEn, 1'b0);
    txIrIn = 1'b0; idle(5); txIrIn = 1'b1; idle(5);
    chk("R6 ir rearmed", irLedEn, 1'b1);
    txIrIn = 1'b0; idle(5);
    // R6 guard timer on remote-control input
    txRcIn = 1'b1; idle(4990);
    chk("R6 rc still on", rcLedEn, 1'b1);
    idle(20);
    chk("R6 rc cut", rcLedEn, 1'b0);
    txRcIn = 1'b0; idle(5); txRcIn = 1'b1; idle(5);
    chk("R6 rc rearmed", rcLedEn, 1'b1);
    txRcIn = 1'b0; idle(5);

    // Random mix of programming and direct drive
    for (int k = 0; k < 60; k++) begin
      int pick;
      pick = int'($urandom % 5);
      if (pick < 3) begin
        doProg(pick);
        chk("R2 random bw", bwHigh, mBw);
      end else begin
        bit ir, rc;
        ir = 1'($urandom); rc = 1'($urandom);
        drive(ir, rc, "R4 random drive");
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule